// File: doc/BRIEF.md
# SDRAM Command Front End

This block holds the three software registers of a single-data-rate SDRAM controller and drives the SDRAM command pins from them. Software steps the device through its power-up sequence by writing one-shot request bits. Each request issues exactly one precharge-all, auto-refresh or load-mode command. The matching register bit flips in the cycle the command reaches the pins, so software can poll for completion.

The block turns the configuration register's private burst-length and CAS-latency codes into the standard mode-register address word. It runs a periodic refresh timer, enters and leaves self-refresh and power-down, and supports a soft reset. It keeps every command away from a cycle in which the data path reports itself busy. It also keeps at least a fixed number of NOP cycles between any two commands.

Top module: `sdram_cmd_front`

## Requirements
- R1: After reset, the init-control register (offset 0x0) reads 0x419, the configuration register (0x4) reads 0x0 and the refresh register (0x8) reads 0x8040. CKE is high and the command pins carry NOP ({cs_n,ras_n,cas_n,we_n}=0111).
- R2: Offsets 0xC and 0x10, and any other unmapped offset, read as 0. Writes to them change no register.
- R3: Writing 1 to init bit 1 issues one precharge-all (code 0010 with address bit 10 high). Writing 1 to bit 0 issues one auto-refresh (code 0001 with CKE high). Writing 1 to bit 2 issues one load-mode (code 0000). The read value of the requesting bit inverts in the same cycle its command appears.
- R4: The load-mode address word is built as follows. Bits 2:0 come from configuration bits 1:0, mapped 00→111, 01→011, 10→010, 11→001. Bit 3 is 0. Bits 6:4 are 011 when configuration bit 2 is 0 and 010 when it is 1. All other address and bank bits are 0.
- R5: Any two commands on the pins are separated by at least 8 NOP cycles.
- R6: One-shot requests pending together are issued one at a time, in the order precharge, then auto-refresh, then load-mode.
- R7: While access_busy is high no command is issued. A waiting request is issued once access_busy falls.
- R8: The refresh period P sits in refresh bits 7:0 and the enable in bit 15. With the enable set and P nonzero, an auto-refresh is issued every P×16 cycles when nothing else is in the way. With the enable clear, or with P zero, no periodic refresh is issued.
- R9: Writing init bit 8 as 1 issues a self-refresh command (code 0001) with CKE low in the same cycle. CKE then stays low with only NOPs on the pins until bit 8 is written 0, which raises CKE.
- R10: Writing init bit 9 as 1 lowers CKE with no command, until bit 9 is written 0. While CKE is low, no periodic refresh is issued. Periodic refresh resumes after CKE rises.
- R11: Writing 1 to init bit 7 returns all three registers to their reset values and discards one-shot requests that are still waiting. Bit 7 always reads 0.
- R12: access_en is high exactly when init bit 3 is set and CKE is high. Init bits 5:4 (density), 10 and 11 are stored and read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| access_busy | input | 1 | Data path occupies the device; commands wait |
| access_en | output | 1 | Normal access permitted |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address, always 0 here |
| sd_addr | output | 13 | Address bus |

## Verification
A register read reflects the state the moment the write edge has passed. When the sequencer is idle and access_busy is low, a one-shot command and its bit inversion appear one clock after the write edge. Commands that follow wait out the 8-NOP gap, so they come 9 cycles apart, and CKE changes one clock after the write that causes them. The bench records every non-NOP command with its cycle number a few nanoseconds after each rising edge. It then checks order, spacing and periodic intervals from that record, after a window longer than the latest cycle any result could be due. Reads and level checks are made on the falling edge.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    localparam int REG_AW = 5;

    localparam logic [REG_AW-1:0] OFS_INIT = 5'h00;
    localparam logic [REG_AW-1:0] OFS_CFG  = 5'h04;
    localparam logic [REG_AW-1:0] OFS_REF  = 5'h08;

    // one-shot request positions (also their bit positions in init control)
    localparam int ONE_CBR = 0;
    localparam int ONE_PRE = 1;
    localparam int ONE_MRS = 2;
    localparam int BIT_RST = 7;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LOADMODE = 4'b0000,
        CMD_REFRESH  = 4'b0001,
        CMD_PRECHG   = 4'b0010,
        CMD_NOP      = 4'b0111
    } sd_cmd_e;

    typedef enum logic [1:0] {
        LP_NONE = 2'd0,
        LP_SELF = 2'd1,
        LP_DOWN = 2'd2
    } lp_e;

    typedef struct packed {
        logic [2:0] tog;
        logic [2:0] req;
        logic       en;
        logic [1:0] dens;
        logic       sr;
        logic       pd;
        logic       bus32;
        logic       col9;
        logic [1:0] bl;
        logic       cas2;
        logic [7:0] per;
        logic       ref_en;
    } reg_state_t;

    localparam reg_state_t REG_RST = '{
        tog: 3'b001, req: 3'b000, en: 1'b1, dens: 2'b01, sr: 1'b0, pd: 1'b0,
        bus32: 1'b1, col9: 1'b0, bl: 2'b00, cas2: 1'b0, per: 8'h40, ref_en: 1'b1
    };

    // standard mode register word, address bits 10:0
    function automatic logic [10:0] mode_word(input logic [1:0] bl, input logic cas2);
        logic [2:0] len;
        case (bl)
            2'b00:   len = 3'b111;
            2'b01:   len = 3'b011;
            2'b10:   len = 3'b010;
            default: len = 3'b001;
        endcase
        return {4'b0000, (cas2 ? 3'b010 : 3'b011), 1'b0, len};
    endfunction

endpackage

// File: rtl/sdc_regs.sv
module sdc_regs
    import sdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [2:0]        issue,
    output logic [31:0]       rdata,
    output logic              soft_rst,
    output logic [2:0]        req,
    output logic              ctl_en,
    output logic              ctl_sr,
    output logic              ctl_pd,
    output logic [1:0]        bl_code,
    output logic              cas2,
    output logic [7:0]        ref_period,
    output logic              ref_en
);

    reg_state_t q, n;
    logic unused_wbits;

    assign unused_wbits = ^{wdata[31:16], wdata[14:12]};
    assign soft_rst     = wr_en && (addr == OFS_INIT) && wdata[BIT_RST];

    always_comb begin
        n     = q;
        n.tog = q.tog ^ issue;
        n.req = q.req & ~issue;
        if (soft_rst) begin
            n = REG_RST;
        end else if (wr_en) begin
            case (addr)
                OFS_INIT: begin
                    n.req   = n.req | wdata[2:0];
                    n.en    = wdata[3];
                    n.dens  = wdata[5:4];
                    n.sr    = wdata[8];
                    n.pd    = wdata[9];
                    n.bus32 = wdata[10];
                    n.col9  = wdata[11];
                end
                OFS_CFG: begin
                    n.bl   = wdata[1:0];
                    n.cas2 = wdata[2];
                end
                OFS_REF: begin
                    n.per    = wdata[7:0];
                    n.ref_en = wdata[15];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= REG_RST;
        else        q <= n;
    end

    always_comb begin
        case (addr)
            OFS_INIT: rdata = {20'd0, q.col9, q.bus32, q.pd, q.sr, 2'b00, q.dens, q.en, q.tog};
            OFS_CFG:  rdata = {29'd0, q.cas2, q.bl};
            OFS_REF:  rdata = {16'd0, q.ref_en, 7'd0, q.per};
            default:  rdata = 32'd0;
        endcase
    end

    assign req        = q.req;
    assign ctl_en     = q.en;
    assign ctl_sr     = q.sr;
    assign ctl_pd     = q.pd;
    assign bl_code    = q.bl;
    assign cas2       = q.cas2;
    assign ref_period = q.per;
    assign ref_en     = q.ref_en;

    // R3
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue[ONE_PRE] && !soft_rst) |=> (q.tog[ONE_PRE] != $past(q.tog[ONE_PRE])));

    // R11
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (q == REG_RST));

endmodule

// File: rtl/sdc_ref_timer.sv
module sdc_ref_timer #(
    parameter int PER_W         = 8,
    parameter int PRESCALE_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             run_en,
    input  logic [PER_W-1:0] period,
    input  logic             ack,
    output logic             pending
);

    localparam int CNT_W = PER_W + PRESCALE_LOG2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pend;
    } tmr_t;

    tmr_t q, n;
    logic [CNT_W-1:0] limit;
    logic             running;

    assign limit   = {period, {PRESCALE_LOG2{1'b0}}} - CNT_W'(1);
    assign running = run_en && (period != '0);

    always_comb begin
        n = q;
        if (ack) n.pend = 1'b0;
        if (running) begin
            if (q.cnt >= limit) begin
                n.cnt  = '0;
                n.pend = 1'b1;
            end else begin
                n.cnt = q.cnt + CNT_W'(1);
            end
        end else begin
            n.cnt = '0;
        end
        if (soft_rst) n = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign pending = q.pend;

    // R10
    timer_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(run_en));

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !ack && !soft_rst) |=> pending);

endmodule

// File: rtl/sdc_cmd_seq.sv
module sdc_cmd_seq
    import sdc_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int NOP_GAP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              busy,
    input  logic [2:0]        req,
    input  logic              ref_pending,
    input  logic              sr_bit,
    input  logic              pd_bit,
    input  logic [1:0]        bl_code,
    input  logic              cas2,
    output logic [2:0]        issue,
    output logic              ref_ack,
    output logic              cke,
    output logic [3:0]        cmd,
    output logic [ADDR_W-1:0] addr
);

    localparam int GW = $clog2(NOP_GAP + 1);

    typedef struct packed {
        sd_cmd_e           cmd;
        logic [ADDR_W-1:0] addr;
        logic              cke;
        logic [GW-1:0]     gap;
        lp_e               lp;
    } seq_t;

    localparam seq_t SEQ_RST = '{cmd: CMD_NOP, addr: '0, cke: 1'b1, gap: '0, lp: LP_NONE};

    seq_t q, n;
    logic go;
    logic leave_lp;

    assign go       = (q.gap == '0) && !busy;
    assign leave_lp = ((q.lp == LP_SELF) && !sr_bit) || ((q.lp == LP_DOWN) && !pd_bit);

    always_comb begin
        n       = q;
        n.cmd   = CMD_NOP;
        n.addr  = '0;
        issue   = '0;
        ref_ack = 1'b0;
        if (q.gap != '0) n.gap = q.gap - GW'(1);

        if (soft_rst) begin
            n.lp  = LP_NONE;
            n.cke = 1'b1;
            if (!q.cke) n.gap = GW'(NOP_GAP);
        end else if (!q.cke) begin
            if (leave_lp) begin
                n.cke = 1'b1;
                n.lp  = LP_NONE;
                n.gap = GW'(NOP_GAP);
            end
        end else if (go) begin
            if (sr_bit) begin
                n.cmd = CMD_REFRESH;
                n.cke = 1'b0;
                n.lp  = LP_SELF;
                n.gap = GW'(NOP_GAP);
            end else if (pd_bit) begin
                n.cke = 1'b0;
                n.lp  = LP_DOWN;
            end else if (ref_pending) begin
                n.cmd   = CMD_REFRESH;
                n.gap   = GW'(NOP_GAP);
                ref_ack = 1'b1;
            end else if (req[ONE_PRE]) begin
                n.cmd          = CMD_PRECHG;
                n.addr[10]     = 1'b1;
                n.gap          = GW'(NOP_GAP);
                issue[ONE_PRE] = 1'b1;
            end else if (req[ONE_CBR]) begin
                n.cmd          = CMD_REFRESH;
                n.gap          = GW'(NOP_GAP);
                issue[ONE_CBR] = 1'b1;
            end else if (req[ONE_MRS]) begin
                n.cmd          = CMD_LOADMODE;
                n.addr         = ADDR_W'(mode_word(bl_code, cas2));
                n.gap          = GW'(NOP_GAP);
                issue[ONE_MRS] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RST;
        else        q <= n;
    end

    assign cke  = q.cke;
    assign cmd  = q.cmd;
    assign addr = q.addr;

    // idle-cycle tally used only by the spacing check
    logic [GW:0] idle_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          idle_q <= (GW + 1)'(NOP_GAP);
        else if (q.cmd != CMD_NOP)           idle_q <= '0;
        else if (idle_q < (GW + 1)'(NOP_GAP)) idle_q <= idle_q + (GW + 1)'(1);
    end

    // R5
    nop_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd != CMD_NOP) |-> (idle_q >= (GW + 1)'(NOP_GAP)));

    // R7
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd != CMD_NOP) |-> !$past(busy));

    // R9
    lowpower_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.cke && $past(!q.cke)) |-> (q.cmd == CMD_NOP));

endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
    import sdc_pkg::*;
#(
    parameter int ADDR_W        = 13,
    parameter int BA_W          = 2,
    parameter int NOP_GAP       = 8,
    parameter int PRESCALE_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              access_busy,
    output logic              access_en,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr
);

    logic       soft_rst;
    logic [2:0] req;
    logic [2:0] issue;
    logic       ctl_en, ctl_sr, ctl_pd;
    logic [1:0] bl_code;
    logic       cas2;
    logic [7:0] ref_period;
    logic       ref_en;
    logic       ref_pending;
    logic       ref_ack;
    logic [3:0] cmd;

    sdc_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .issue      (issue),
        .rdata      (reg_rdata),
        .soft_rst   (soft_rst),
        .req        (req),
        .ctl_en     (ctl_en),
        .ctl_sr     (ctl_sr),
        .ctl_pd     (ctl_pd),
        .bl_code    (bl_code),
        .cas2       (cas2),
        .ref_period (ref_period),
        .ref_en     (ref_en)
    );

    sdc_ref_timer #(
        .PER_W         (8),
        .PRESCALE_LOG2 (PRESCALE_LOG2)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .run_en   (ref_en && sd_cke),
        .period   (ref_period),
        .ack      (ref_ack),
        .pending  (ref_pending)
    );

    sdc_cmd_seq #(
        .ADDR_W  (ADDR_W),
        .NOP_GAP (NOP_GAP)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .busy        (access_busy),
        .req         (req),
        .ref_pending (ref_pending),
        .sr_bit      (ctl_sr),
        .pd_bit      (ctl_pd),
        .bl_code     (bl_code),
        .cas2        (cas2),
        .issue       (issue),
        .ref_ack     (ref_ack),
        .cke         (sd_cke),
        .cmd         (cmd),
        .addr        (sd_addr)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_ba     = '0;
    assign access_en = ctl_en && sd_cke;

    // R4
    mode_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LOADMODE) |-> (!sd_addr[3] && (sd_addr[6:4] inside {3'b010, 3'b011})
                                   && (sd_addr[ADDR_W-1:7] == '0)));

    // R12
    access_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_cke |-> !access_en);

endmodule

// File: tb/tb_sdram_cmd_front.sv
`timescale 1ns/1ps
module tb_sdram_cmd_front;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = 5'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        access_busy = 1'b0;
    logic        access_en;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;

    always #10 clk = ~clk;

    sdram_cmd_front dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .access_busy(access_busy),
        .access_en(access_en), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
    );

    int n_chk = 0;
    int n_bad = 0;

    // command record, stamped a few ns after each rising edge
    int          cyc = 0;
    int          log_n = 0;
    logic [3:0]  log_code [256];
    logic [12:0] log_addr [256];
    logic        log_cke  [256];
    int          log_cyc  [256];

    always @(posedge clk) begin
        #3;
        cyc = cyc + 1;
        if (rst_n && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != 4'b0111 && log_n < 256) begin
            log_code[log_n] = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            log_addr[log_n] = sd_addr;
            log_cke[log_n]  = sd_cke;
            log_cyc[log_n]  = cyc;
            log_n = log_n + 1;
        end
    end

    // {config[3:0], expected address[11:0]} for the load-mode word
    localparam logic [15:0] MODE_VEC [8] = '{
        16'h0_037, 16'h1_033, 16'h2_032, 16'h3_031,
        16'h4_027, 16'h5_023, 16'h6_022, 16'h7_021
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [2:0]  tog;
        int          mk;
        int          mk2;
        int          ok;

        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1 reset state
        rd(5'h00, v); chk("R1 init", v, 32'h419);
        rd(5'h04, v); chk("R1 cfg", v, 32'h0);
        rd(5'h08, v); chk("R1 ref", v, 32'h8040);
        chk("R1 cke", {31'd0, sd_cke}, 32'd1);
        chk("R1 cmd", {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 32'h7);
        tog = 3'b001;

        // R2 reserved offsets
        wr(5'h0C, 32'hFFFF_FFFF);
        wr(5'h10, 32'hFFFF_FFFF);
        rd(5'h0C, v); chk("R2 read 0xC", v, 32'h0);
        rd(5'h10, v); chk("R2 read 0x10", v, 32'h0);
        rd(5'h00, v); chk("R2 init untouched", v, 32'h419);
        rd(5'h08, v); chk("R2 ref untouched", v, 32'h8040);

        // stop periodic refresh for the directed parts
        wr(5'h08, 32'h0000_0040);
        rd(5'h08, v); chk("R8 ref disabled readback", v, 32'h40);

        // R4 table of mode words
        foreach (MODE_VEC[i]) begin
            wr(5'h04, {28'd0, MODE_VEC[i][15:12]});
            mk = log_n;
            wr(5'h00, 32'h41C);
            wait_cyc(12);
            chk("R4 one command", log_n - mk, 1);
            chk("R4 load-mode code", {28'd0, log_code[mk]}, 32'h0);
            chk("R4 mode address", {19'd0, log_addr[mk]}, {20'd0, MODE_VEC[i][11:0]});
            tog[2] = ~tog[2];
            rd(5'h00, v); chk("R3 mode bit toggled", {29'd0, v[2:0]}, {29'd0, tog});
        end

        // R3 precharge and auto-refresh
        mk = log_n;
        wr(5'h00, 32'h41A);
        wait_cyc(12);
        chk("R3 precharge code", {28'd0, log_code[mk]}, 32'h2);
        chk("R3 precharge A10", {31'd0, log_addr[mk][10]}, 32'd1);
        tog[1] = ~tog[1];
        rd(5'h00, v); chk("R3 precharge bit toggled", {29'd0, v[2:0]}, {29'd0, tog});
        mk = log_n;
        wr(5'h00, 32'h419);
        wait_cyc(12);
        chk("R3 refresh code", {28'd0, log_code[mk]}, 32'h1);
        chk("R3 refresh cke", {31'd0, log_cke[mk]}, 32'd1);
        tog[0] = ~tog[0];
        rd(5'h00, v); chk("R3 refresh bit toggled", {29'd0, v[2:0]}, {29'd0, tog});

        // R6 priority, R5 spacing
        mk = log_n;
        wr(5'h00, 32'h41F);
        wait_cyc(40);
        chk("R6 three commands", log_n - mk, 3);
        chk("R6 first precharge", {28'd0, log_code[mk]}, 32'h2);
        chk("R6 second refresh", {28'd0, log_code[mk+1]}, 32'h1);
        chk("R6 third load-mode", {28'd0, log_code[mk+2]}, 32'h0);
        chk("R5 gap 1", {31'd0, (log_cyc[mk+1] - log_cyc[mk]) >= 9}, 32'd1);
        chk("R5 gap 2", {31'd0, (log_cyc[mk+2] - log_cyc[mk+1]) >= 9}, 32'd1);
        tog = ~tog;
        rd(5'h00, v); chk("R3 all bits toggled", {29'd0, v[2:0]}, {29'd0, tog});

        // R7 busy holds commands
        @(negedge clk); access_busy = 1'b1;
        mk = log_n;
        wr(5'h00, 32'h41A);
        wait_cyc(20);
        chk("R7 held while busy", log_n - mk, 0);
        access_busy = 1'b0;
        wait_cyc(5);
        chk("R7 issued after busy", log_n - mk, 1);
        chk("R7 issued precharge", {28'd0, log_code[mk]}, 32'h2);
        tog[1] = ~tog[1];

        // R8 periodic refresh every 16 cycles for P=1
        mk = log_n;
        wr(5'h08, 32'h0000_8001);
        wait_cyc(100);
        chk("R8 several refreshes", {31'd0, (log_n - mk) >= 5}, 32'd1);
        ok = 1;
        for (int k = mk + 1; k < log_n; k++) begin
            if (log_cyc[k] - log_cyc[k-1] != 16 || log_code[k] != 4'h1) ok = 0;
        end
        chk("R8 interval 16", ok, 1);
        wr(5'h08, 32'h0000_0001);
        wait_cyc(20);
        mk = log_n;
        wait_cyc(60);
        chk("R8 disabled none", log_n - mk, 0);
        wr(5'h08, 32'h0000_8000);
        mk = log_n;
        wait_cyc(60);
        chk("R8 period zero none", log_n - mk, 0);

        // R9 self-refresh with refresh timer running
        wr(5'h08, 32'h0000_8001);
        wait_cyc(3);
        mk = log_n;
        wr(5'h00, 32'h518);
        wait_cyc(15);
        chk("R9 entry logged", {31'd0, log_n > mk}, 32'd1);
        chk("R9 entry code", {28'd0, log_code[log_n-1]}, 32'h1);
        chk("R9 entry cke low", {31'd0, log_cke[log_n-1]}, 32'd0);
        mk2 = log_n;
        wait_cyc(80);
        chk("R9 quiet in self-refresh", log_n - mk2, 0);
        chk("R9 cke low", {31'd0, sd_cke}, 32'd0);
        rd(5'h00, v); chk("R9 bit readback", {31'd0, v[8]}, 32'd1);
        wr(5'h00, 32'h418);
        wait_cyc(2);
        chk("R9 cke raised", {31'd0, sd_cke}, 32'd1);
        mk2 = log_n;
        wait_cyc(40);
        chk("R10 refresh resumes", {31'd0, log_n > mk2}, 32'd1);

        // R10 power-down
        wr(5'h00, 32'h618);
        wait_cyc(15);
        mk = log_n;
        wait_cyc(80);
        chk("R10 no refresh in power-down", log_n - mk, 0);
        chk("R10 cke low", {31'd0, sd_cke}, 32'd0);
        chk("R12 access off in power-down", {31'd0, access_en}, 32'd0);
        wr(5'h00, 32'h418);
        wait_cyc(2);
        chk("R10 cke raised", {31'd0, sd_cke}, 32'd1);
        chk("R12 access back on", {31'd0, access_en}, 32'd1);
        wr(5'h08, 32'h0000_0040);
        wait_cyc(20);

        // R11 soft reset drops a waiting request
        @(negedge clk); access_busy = 1'b1;
        wr(5'h00, 32'h41A);
        wr(5'h04, 32'h5);
        wr(5'h00, 32'h0000_0080);
        rd(5'h00, v); chk("R11 init reset", v, 32'h419);
        rd(5'h04, v); chk("R11 cfg reset", v, 32'h0);
        rd(5'h08, v); chk("R11 ref reset", v, 32'h8040);
        access_busy = 1'b0;
        mk = log_n;
        wait_cyc(20);
        chk("R11 request discarded", log_n - mk, 0);

        // R12 stored fields and access enable
        wr(5'h00, 32'hC30);
        rd(5'h00, v); chk("R12 fields readback", v, 32'hC31);
        chk("R12 access off", {31'd0, access_en}, 32'd0);
        wr(5'h00, 32'h418);
        wait_cyc(1);
        chk("R12 access on", {31'd0, access_en}, 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule